// File: doc/BRIEF.md
# Oldest Stalled Load Tracker

This block sits beside a load/store queue. It remembers the single load that has to be replayed after a partial store-to-load forwarding conflict. It also remembers the single load that was refused by the memory port. When several loads report the same condition, it keeps the oldest one, judged by sequence number.

A smaller sequence number means an older instruction. With `WRAP_CMP=1`, age is judged by the sign of the modular difference, so sequence numbers may wrap.

For a forwarding conflict, the block records both the load and the store that blocks it. It holds the stall until that exact store reports writeback. On that writeback it drops the stall and emits a one-cycle replay pulse that carries the load's sequence number.

For a memory-port refusal, the block records a blocked flag and the load's sequence number. The issue logic sets a separate handled flag with a strobe, and drops the record with a clear strobe. A squash with boundary S removes any record whose load is younger than S.

All outputs are registered. Every effect of an input is visible after the rising clock edge that samples it.

Top module: `oldest_load_tracker`

## Requirements
- R1: A stall report is recorded when no stall is held, or when its load sequence number is strictly older than the held load. Recording sets `stall_o` and captures both the load and the store sequence numbers.
- R2: A stall report whose load is equal to or younger than the held load leaves all stall outputs unchanged.
- R3: A writeback whose store sequence number equals the held store clears `stall_o`. In the same cycle, `replay_o` is high for exactly one cycle with `replay_seq_o` equal to the released load. A writeback of any other store has no effect.
- R4: When a release and a stall report arrive in the same cycle, the release takes effect first. The report is then judged against an empty state, so it is always recorded.
- R5: A blocked report is recorded when no blocked load is held, or when the reporter is not younger than the held load. Recording sets `blk_o`, clears `blk_handled_o` and stores the reporter's sequence number.
- R6: A blocked report whose load is younger than the held blocked load leaves `blk_o`, `blk_seq_o` and `blk_handled_o` unchanged.
- R7: The acknowledge strobe sets `blk_handled_o` while a blocked load is held. The clear strobe clears both `blk_o` and `blk_handled_o`. A clear and a report in the same cycle leave the new report recorded and unhandled.
- R8: A squash with boundary S clears any held stall or blocked entry whose load is younger than S, and no replay pulse is produced. A same-cycle report whose load is younger than S is ignored.
- R9: After reset, every flag output is 0 and every sequence output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_vld_i | input | 1 | Partial-forwarding stall report |
| stall_load_seq_i | input | SEQ_W | Sequence number of the reporting load |
| stall_store_seq_i | input | SEQ_W | Sequence number of the blocking store |
| wb_vld_i | input | 1 | Store writeback complete |
| wb_store_seq_i | input | SEQ_W | Sequence number of the store written back |
| blk_vld_i | input | 1 | Memory-port refusal report |
| blk_load_seq_i | input | SEQ_W | Sequence number of the refused load |
| blk_clr_i | input | 1 | Clear the blocked record |
| blk_ack_i | input | 1 | Mark the blocked record handled |
| squash_vld_i | input | 1 | Squash strobe |
| squash_seq_i | input | SEQ_W | Squash boundary; younger loads are removed |
| stall_o | output | 1 | A stall is held |
| stall_load_seq_o | output | SEQ_W | Held stalled load |
| stall_store_seq_o | output | SEQ_W | Store the held load waits on |
| replay_o | output | 1 | One-cycle replay pulse |
| replay_seq_o | output | SEQ_W | Load to replay |
| blk_o | output | 1 | A blocked load is held |
| blk_handled_o | output | 1 | The blocked load has been handled |
| blk_seq_o | output | SEQ_W | Held blocked load |

## Verification
The bench builds the block with `SEQ_W=8` and the plain comparison (`WRAP_CMP=0`). With these values the sequence numbers are short, and the test cases cover the age boundaries that matter: strictly older, equal and younger reporters. It also reaches a squash boundary sitting exactly between the held stall and the held blocked load, and the same-cycle release/report and clear/report orderings.

// File: rtl/olt_pkg.sv
package olt_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD   = 2'd0,
    UPD_RECORD = 2'd1,
    UPD_DROP   = 2'd2
  } upd_e;
endpackage

// File: rtl/olt_seq_older.sv
module olt_seq_older #(
  parameter int unsigned SEQ_W    = 16,
  parameter bit          WRAP_CMP = 1'b0
) (
  input  logic [SEQ_W-1:0] a_i,
  input  logic [SEQ_W-1:0] b_i,
  output logic             a_older_o
);
  generate
    if (WRAP_CMP) begin : g_wrap
      logic [SEQ_W-1:0] diff;
      assign diff      = a_i - b_i;
      assign a_older_o = diff[SEQ_W-1];
    end else begin : g_plain
      assign a_older_o = a_i < b_i;
    end
  endgenerate
endmodule

// File: rtl/olt_stall_trk.sv
module olt_stall_trk
  import olt_pkg::*;
#(
  parameter int unsigned SEQ_W    = 16,
  parameter bit          WRAP_CMP = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rpt_vld_i,
  input  logic [SEQ_W-1:0] rpt_load_i,
  input  logic [SEQ_W-1:0] rpt_store_i,
  input  logic             wb_vld_i,
  input  logic [SEQ_W-1:0] wb_store_i,
  input  logic             squash_vld_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic             stall_o,
  output logic [SEQ_W-1:0] load_o,
  output logic [SEQ_W-1:0] store_o,
  output logic             replay_o,
  output logic [SEQ_W-1:0] replay_seq_o
);
  logic             stall_q;
  logic [SEQ_W-1:0] load_q, store_q;
  logic             replay_q;
  logic [SEQ_W-1:0] replay_seq_q;
  logic             sq_older_held, sq_older_rpt, rpt_older_held;
  logic             release_hit, kill_held, held, rpt_ok;
  upd_e             upd;

  olt_seq_older #(.SEQ_W(SEQ_W), .WRAP_CMP(WRAP_CMP)) u_cmp_kill (
    .a_i(squash_seq_i), .b_i(load_q), .a_older_o(sq_older_held));
  olt_seq_older #(.SEQ_W(SEQ_W), .WRAP_CMP(WRAP_CMP)) u_cmp_rkill (
    .a_i(squash_seq_i), .b_i(rpt_load_i), .a_older_o(sq_older_rpt));
  olt_seq_older #(.SEQ_W(SEQ_W), .WRAP_CMP(WRAP_CMP)) u_cmp_age (
    .a_i(rpt_load_i), .b_i(load_q), .a_older_o(rpt_older_held));

  // release is applied before the report is judged
  assign release_hit = stall_q && wb_vld_i && (wb_store_i == store_q);
  assign kill_held   = squash_vld_i && sq_older_held;
  assign held        = stall_q && !release_hit && !kill_held;
  assign rpt_ok      = rpt_vld_i && !(squash_vld_i && sq_older_rpt) &&
                       (!held || rpt_older_held);

  always_comb begin
    if (rpt_ok)     upd = UPD_RECORD;
    else if (!held) upd = UPD_DROP;
    else            upd = UPD_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_q      <= 1'b0;
      load_q       <= '0;
      store_q      <= '0;
      replay_q     <= 1'b0;
      replay_seq_q <= '0;
    end else begin
      replay_q <= release_hit;
      if (release_hit) replay_seq_q <= load_q;
      unique case (upd)
        UPD_RECORD: begin
          stall_q <= 1'b1;
          load_q  <= rpt_load_i;
          store_q <= rpt_store_i;
        end
        UPD_DROP: stall_q <= 1'b0;
        default:  ;
      endcase
    end
  end

  assign stall_o      = stall_q;
  assign load_o       = load_q;
  assign store_o      = store_q;
  assign replay_o     = replay_q;
  assign replay_seq_o = replay_seq_q;

  AST_RELEASE_REPLAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_q && wb_vld_i && wb_store_i == store_q) |=>
      (replay_o && replay_seq_o == $past(load_q))); // R3
  AST_NOT_OLDER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_q && !wb_vld_i && !squash_vld_i && rpt_vld_i && !(rpt_load_i < load_q) && !WRAP_CMP) |=>
      (stall_o && $stable(load_q) && $stable(store_q))); // R2
  AST_RECORD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_q && rpt_vld_i && !squash_vld_i) |=>
      (stall_o && load_o == $past(rpt_load_i) && store_o == $past(rpt_store_i))); // R1
  AST_SQUASH_NO_REPLAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_vld_i && !wb_vld_i) |=> !replay_o); // R8
endmodule

// File: rtl/olt_blk_trk.sv
module olt_blk_trk
  import olt_pkg::*;
#(
  parameter int unsigned SEQ_W    = 16,
  parameter bit          WRAP_CMP = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rpt_vld_i,
  input  logic [SEQ_W-1:0] rpt_load_i,
  input  logic             clr_i,
  input  logic             ack_i,
  input  logic             squash_vld_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic             blk_o,
  output logic             handled_o,
  output logic [SEQ_W-1:0] seq_o
);
  logic             blk_q, handled_q;
  logic [SEQ_W-1:0] seq_q;
  logic             sq_older_held, sq_older_rpt, held_older_rpt;
  logic             kill_held, held, rpt_ok;
  upd_e             upd;

  olt_seq_older #(.SEQ_W(SEQ_W), .WRAP_CMP(WRAP_CMP)) u_cmp_kill (
    .a_i(squash_seq_i), .b_i(seq_q), .a_older_o(sq_older_held));
  olt_seq_older #(.SEQ_W(SEQ_W), .WRAP_CMP(WRAP_CMP)) u_cmp_rkill (
    .a_i(squash_seq_i), .b_i(rpt_load_i), .a_older_o(sq_older_rpt));
  olt_seq_older #(.SEQ_W(SEQ_W), .WRAP_CMP(WRAP_CMP)) u_cmp_age (
    .a_i(seq_q), .b_i(rpt_load_i), .a_older_o(held_older_rpt));

  assign kill_held = squash_vld_i && sq_older_held;
  assign held      = blk_q && !clr_i && !kill_held;
  assign rpt_ok    = rpt_vld_i && !(squash_vld_i && sq_older_rpt) &&
                     !(held && held_older_rpt);

  always_comb begin
    if (rpt_ok)     upd = UPD_RECORD;
    else if (!held) upd = UPD_DROP;
    else            upd = UPD_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q     <= 1'b0;
      handled_q <= 1'b0;
      seq_q     <= '0;
    end else begin
      unique case (upd)
        UPD_RECORD: begin
          blk_q     <= 1'b1;
          handled_q <= 1'b0;
          seq_q     <= rpt_load_i;
        end
        UPD_DROP: begin
          blk_q     <= 1'b0;
          handled_q <= 1'b0;
        end
        default: if (ack_i) handled_q <= 1'b1;
      endcase
    end
  end

  assign blk_o     = blk_q;
  assign handled_o = handled_q;
  assign seq_o     = seq_q;

  AST_HANDLED_NEEDS_BLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handled_o |-> blk_o); // R7
  AST_BLK_RECORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_vld_i && !squash_vld_i && (!blk_q || clr_i)) |=>
      (blk_o && !handled_o && seq_o == $past(rpt_load_i))); // R5
  AST_BLK_YOUNGER_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_q && !clr_i && !squash_vld_i && !ack_i && rpt_vld_i && !WRAP_CMP && seq_q < rpt_load_i) |=>
      (blk_o && $stable(seq_q) && $stable(handled_q))); // R6
endmodule

// File: rtl/oldest_load_tracker.sv
module oldest_load_tracker #(
  parameter int unsigned SEQ_W    = 16,
  parameter bit          WRAP_CMP = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_vld_i,
  input  logic [SEQ_W-1:0] stall_load_seq_i,
  input  logic [SEQ_W-1:0] stall_store_seq_i,
  input  logic             wb_vld_i,
  input  logic [SEQ_W-1:0] wb_store_seq_i,
  input  logic             blk_vld_i,
  input  logic [SEQ_W-1:0] blk_load_seq_i,
  input  logic             blk_clr_i,
  input  logic             blk_ack_i,
  input  logic             squash_vld_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic             stall_o,
  output logic [SEQ_W-1:0] stall_load_seq_o,
  output logic [SEQ_W-1:0] stall_store_seq_o,
  output logic             replay_o,
  output logic [SEQ_W-1:0] replay_seq_o,
  output logic             blk_o,
  output logic             blk_handled_o,
  output logic [SEQ_W-1:0] blk_seq_o
);
  olt_stall_trk #(.SEQ_W(SEQ_W), .WRAP_CMP(WRAP_CMP)) u_stall (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rpt_vld_i    (stall_vld_i),
    .rpt_load_i   (stall_load_seq_i),
    .rpt_store_i  (stall_store_seq_i),
    .wb_vld_i     (wb_vld_i),
    .wb_store_i   (wb_store_seq_i),
    .squash_vld_i (squash_vld_i),
    .squash_seq_i (squash_seq_i),
    .stall_o      (stall_o),
    .load_o       (stall_load_seq_o),
    .store_o      (stall_store_seq_o),
    .replay_o     (replay_o),
    .replay_seq_o (replay_seq_o)
  );

  olt_blk_trk #(.SEQ_W(SEQ_W), .WRAP_CMP(WRAP_CMP)) u_blk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rpt_vld_i    (blk_vld_i),
    .rpt_load_i   (blk_load_seq_i),
    .clr_i        (blk_clr_i),
    .ack_i        (blk_ack_i),
    .squash_vld_i (squash_vld_i),
    .squash_seq_i (squash_seq_i),
    .blk_o        (blk_o),
    .handled_o    (blk_handled_o),
    .seq_o        (blk_seq_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!stall_o && !replay_o && !blk_o)); // R9
endmodule

// File: tb/oldest_load_tracker_bench.sv
module oldest_load_tracker_bench;
  localparam int unsigned SEQ_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic stall_vld_i = 1'b0, wb_vld_i = 1'b0, blk_vld_i = 1'b0;
  logic blk_clr_i = 1'b0, blk_ack_i = 1'b0, squash_vld_i = 1'b0;
  logic [SEQ_W-1:0] stall_load_seq_i = '0, stall_store_seq_i = '0;
  logic [SEQ_W-1:0] wb_store_seq_i = '0, blk_load_seq_i = '0, squash_seq_i = '0;
  logic stall_o, replay_o, blk_o, blk_handled_o;
  logic [SEQ_W-1:0] stall_load_seq_o, stall_store_seq_o, replay_seq_o, blk_seq_o;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  oldest_load_tracker #(.SEQ_W(SEQ_W), .WRAP_CMP(1'b0)) u_oldest_load_tracker (
    .clk_i(clk), .rst_ni(rst_ni),
    .stall_vld_i(stall_vld_i), .stall_load_seq_i(stall_load_seq_i),
    .stall_store_seq_i(stall_store_seq_i),
    .wb_vld_i(wb_vld_i), .wb_store_seq_i(wb_store_seq_i),
    .blk_vld_i(blk_vld_i), .blk_load_seq_i(blk_load_seq_i),
    .blk_clr_i(blk_clr_i), .blk_ack_i(blk_ack_i),
    .squash_vld_i(squash_vld_i), .squash_seq_i(squash_seq_i),
    .stall_o(stall_o), .stall_load_seq_o(stall_load_seq_o),
    .stall_store_seq_o(stall_store_seq_o),
    .replay_o(replay_o), .replay_seq_o(replay_seq_o),
    .blk_o(blk_o), .blk_handled_o(blk_handled_o), .blk_seq_o(blk_seq_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    stall_vld_i = 0; wb_vld_i = 0; blk_vld_i = 0;
    blk_clr_i = 0; blk_ack_i = 0; squash_vld_i = 0;
  endtask

  // inputs change 1 ns after an edge; results are read 1 ns after the next
  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic stall_rpt(input int ld, input int st);
    stall_vld_i = 1; stall_load_seq_i = SEQ_W'(ld); stall_store_seq_i = SEQ_W'(st);
  endtask

  task automatic wb(input int st);
    wb_vld_i = 1; wb_store_seq_i = SEQ_W'(st);
  endtask

  task automatic blk_rpt(input int ld);
    blk_vld_i = 1; blk_load_seq_i = SEQ_W'(ld);
  endtask

  task automatic t_reset();
    chk("R9", "stall_o", int'(stall_o), 0);
    chk("R9", "replay_o", int'(replay_o), 0);
    chk("R9", "blk_o", int'(blk_o), 0);
    chk("R9", "blk_handled_o", int'(blk_handled_o), 0);
    chk("R9", "stall_load_seq_o", int'(stall_load_seq_o), 0);
    chk("R9", "blk_seq_o", int'(blk_seq_o), 0);
  endtask

  task automatic t_stall();
    stall_rpt(10, 5); step();
    chk("R1", "stall_o", int'(stall_o), 1);
    chk("R1", "load", int'(stall_load_seq_o), 10);
    chk("R1", "store", int'(stall_store_seq_o), 5);
    stall_rpt(12, 3); step();
    chk("R2", "younger load", int'(stall_load_seq_o), 10);
    chk("R2", "younger store", int'(stall_store_seq_o), 5);
    stall_rpt(10, 2); step();
    chk("R2", "equal store", int'(stall_store_seq_o), 5);
    stall_rpt(7, 4); step();
    chk("R1", "older load", int'(stall_load_seq_o), 7);
    chk("R1", "older store", int'(stall_store_seq_o), 4);
    wb(5); step();
    chk("R3", "other wb stall", int'(stall_o), 1);
    chk("R3", "other wb replay", int'(replay_o), 0);
    wb(4); step();
    chk("R3", "release stall", int'(stall_o), 0);
    chk("R3", "replay", int'(replay_o), 1);
    chk("R3", "replay seq", int'(replay_seq_o), 7);
    step();
    chk("R3", "pulse width", int'(replay_o), 0);
  endtask

  task automatic t_same_cycle();
    stall_rpt(20, 9); step();
    wb(9); stall_rpt(30, 11); step();
    chk("R4", "stall_o", int'(stall_o), 1);
    chk("R4", "load", int'(stall_load_seq_o), 30);
    chk("R4", "store", int'(stall_store_seq_o), 11);
    chk("R4", "replay", int'(replay_o), 1);
    chk("R4", "replay seq", int'(replay_seq_o), 20);
    wb(11); step(); step();
    chk("R3", "cleanup", int'(stall_o), 0);
  endtask

  task automatic t_blk();
    blk_rpt(40); step();
    chk("R5", "blk_o", int'(blk_o), 1);
    chk("R5", "handled", int'(blk_handled_o), 0);
    chk("R5", "seq", int'(blk_seq_o), 40);
    blk_ack_i = 1; step();
    chk("R7", "ack", int'(blk_handled_o), 1);
    blk_rpt(50); step();
    chk("R6", "seq kept", int'(blk_seq_o), 40);
    chk("R6", "handled kept", int'(blk_handled_o), 1);
    chk("R6", "blk kept", int'(blk_o), 1);
    blk_rpt(40); step();
    chk("R5", "equal rerecord handled", int'(blk_handled_o), 0);
    blk_rpt(33); step();
    chk("R5", "older seq", int'(blk_seq_o), 33);
    blk_ack_i = 1; step();
    blk_clr_i = 1; blk_rpt(60); step();
    chk("R7", "clr+rpt blk", int'(blk_o), 1);
    chk("R7", "clr+rpt seq", int'(blk_seq_o), 60);
    chk("R7", "clr+rpt handled", int'(blk_handled_o), 0);
    blk_ack_i = 1; step();
    blk_clr_i = 1; step();
    chk("R7", "clr blk", int'(blk_o), 0);
    chk("R7", "clr handled", int'(blk_handled_o), 0);
  endtask

  task automatic t_squash();
    stall_rpt(15, 2); blk_rpt(18); step();
    squash_vld_i = 1; squash_seq_i = 16; step();
    chk("R8", "older stall kept", int'(stall_o), 1);
    chk("R8", "younger blk cleared", int'(blk_o), 0);
    squash_vld_i = 1; squash_seq_i = 14; step();
    chk("R8", "stall cleared", int'(stall_o), 0);
    chk("R8", "no replay", int'(replay_o), 0);
    squash_vld_i = 1; squash_seq_i = 20; stall_rpt(25, 1); blk_rpt(26); step();
    chk("R8", "same-cycle stall ignored", int'(stall_o), 0);
    chk("R8", "same-cycle blk ignored", int'(blk_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_ni = 1;
    step();
    t_reset();
    t_stall();
    t_same_cycle();
    t_blk();
    t_squash();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule